// File: doc/BRIEF.md
# DDR SDRAM Refresh Scheduler

This block sits on the controller side of a single-rank, four-bank DDR SDRAM and decides when refresh happens. A free-running interval timer adds one owed refresh for every average refresh period. The period is derived from the clock period and the refresh interval, and the default gives 15.6 µs at 133 MHz. While refreshes are owed, the block asks the command arbiter for a slot. Once it holds the slot, it asks the bank tracker to close every bank. It then issues a refresh command and needs no row address, because the memory keeps its own refresh counter.

Owed refreshes may pile up to a posting limit. An urgency flag tells the arbiter when that limit has been reached. Consecutive refreshes are spaced by at least the refresh cycle time, and activates are held off for that same time. A self-refresh request takes the next refresh slot and issues that refresh with the clock enable low. The clock enable stays low until the request is withdrawn. After exit, the block holds non-read commands and read commands for separate delays. It also clears the owed count and restarts the interval timer.

Top module: `ref_sched`

## Requirements
- R1: After reset: ref_req, pre_all_req, cmd_ref and ref_urgent are 0, and cke, act_ok and rd_ok are 1.
- R2: One refresh becomes owed each REFI_CYC = REFI_NS*1000/CLK_PS cycles, counted from reset release, and the first comes after REFI_CYC edges. ref_req is raised no earlier than that and stays high until arb_gnt is seen.
- R3: After the grant, pre_all_req stays high until banks_idle is seen high. cmd_ref is a one-cycle pulse that follows only in the cycle after banks_idle was sampled high.
- R4: ref_urgent is 1 exactly when the owed count has reached POST_MAX and drops as soon as it is below. The count saturates at POST_MAX, so ticks beyond it are dropped.
- R5: Two cmd_ref pulses are at least TRFC_CYC cycles apart. act_ok is 0 during the cycle of cmd_ref and the TRFC_CYC-1 cycles after it, and is 1 again TRFC_CYC cycles after cmd_ref.
- R6: With sr_want high, the next refresh is issued with cke low in the same cycle. cke stays low while sr_want is high, and no cmd_ref is issued while cke is low.
- R7: cke rises on the first edge that samples sr_want low in self-refresh. act_ok returns TXSNR_CYC edges after that edge and rd_ok returns TXSRD_CYC edges after it.
- R8: Self-refresh exit clears the owed count and restarts the interval, so the next ref_req comes only REFI_CYC+1 edges after exit.
- R9: If sr_want rises while an auto-refresh is waiting for its grant, the granted refresh becomes the self-refresh entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arb_gnt | input | 1 | Command arbiter grants the refresh slot |
| banks_idle | input | 1 | Bank tracker reports all banks precharged |
| sr_want | input | 1 | Level request to enter and stay in self-refresh |
| ref_req | output | 1 | Refresh slot request to the arbiter |
| pre_all_req | output | 1 | Request to close all banks |
| cmd_ref | output | 1 | Refresh command pulse |
| cke | output | 1 | Clock enable to the memory |
| ref_urgent | output | 1 | Owed count at the posting limit |
| act_ok | output | 1 | Activate and other non-read commands allowed |
| rd_ok | output | 1 | Read commands allowed |

## Verification
The hardest case to reach is the saturated posting limit. The bench holds the grant low across more ticks than the limit allows, then releases it. It counts the refreshes issued before the next tick: that count shows whether the extra ticks were dropped. A second hard case is the owed-count clear on self-refresh exit. To reach it, the bench enters self-refresh while an auto-refresh is already owed and waiting. It then checks that no request appears until a full interval after exit.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;
    typedef enum logic [2:0] {
        RS_IDLE  = 3'd0,
        RS_ARB   = 3'd1,
        RS_PRE   = 3'd2,
        RS_ISSUE = 3'd3,
        RS_SELF  = 3'd4
    } rs_state_e;
endpackage

// File: rtl/rs_interval.sv
module rs_interval #(
    parameter int LIM = 2080
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CW = (LIM > 2) ? $clog2(LIM) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIM - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = tick ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rs_delay.sv
module rs_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    assign zero = (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (load)       cnt_d = load_val;
        else if (!zero) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ref_sched.sv
module ref_sched
    import ref_sched_pkg::*;
#(
    parameter int CLK_PS    = 7500,
    parameter int REFI_NS   = 15600,
    parameter int TRFC_CYC  = 10,
    parameter int TXSNR_CYC = 10,
    parameter int TXSRD_CYC = 200,
    parameter int POST_MAX  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arb_gnt,
    input  logic banks_idle,
    input  logic sr_want,
    output logic ref_req,
    output logic pre_all_req,
    output logic cmd_ref,
    output logic cke,
    output logic ref_urgent,
    output logic act_ok,
    output logic rd_ok
);
    localparam int REFI_CYC = (REFI_NS * 1000) / CLK_PS;
    localparam int OW       = $clog2(POST_MAX + 1) + 1;
    localparam int DMAX     = (TXSRD_CYC > TXSNR_CYC) ?
                              ((TXSRD_CYC > TRFC_CYC) ? TXSRD_CYC : TRFC_CYC) :
                              ((TXSNR_CYC > TRFC_CYC) ? TXSNR_CYC : TRFC_CYC);
    localparam int DW       = $clog2(DMAX + 1);
    localparam int NDLY     = 3;
    localparam int unsigned DLY_VAL [NDLY] = '{TRFC_CYC - 1, TXSNR_CYC, TXSRD_CYC};
    localparam logic signed [OW-1:0] OWED_MAX = OW'(POST_MAX);
    localparam logic signed [OW-1:0] OWED_ONE = OW'(1);

    typedef struct packed {
        rs_state_e              st;
        logic                   sr_sel;
        logic                   cke;
        logic                   urg;
        logic signed [OW-1:0]   owed;
    } regs_t;

    regs_t r_d, r_q;

    logic            tick;
    logic            restart;
    logic [NDLY-1:0] dly_load;
    logic [NDLY-1:0] dly_zero;
    logic            owed_inc;
    logic            owed_dec;
    logic            owed_clr;

    rs_interval #(.LIM(REFI_CYC)) i_interval (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.cke),
        .restart (restart),
        .tick    (tick)
    );

    // index 0: refresh cycle gap, 1: exit to non-read, 2: exit to read
    for (genvar g = 0; g < NDLY; g++) begin : g_dly
        rs_delay #(.W(DW)) i_dly (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (dly_load[g]),
            .load_val (DW'(DLY_VAL[g])),
            .zero     (dly_zero[g])
        );
    end

    always_comb begin
        r_d      = r_q;
        dly_load = '0;
        restart  = 1'b0;
        owed_inc = tick && (r_q.owed < OWED_MAX);
        owed_dec = 1'b0;
        owed_clr = 1'b0;

        unique case (r_q.st)
            RS_IDLE: begin
                if (sr_want) begin
                    r_d.sr_sel = 1'b1;
                    r_d.st     = RS_ARB;
                end else if (r_q.owed > '0) begin
                    r_d.sr_sel = 1'b0;
                    r_d.st     = RS_ARB;
                end
            end
            RS_ARB: begin
                r_d.sr_sel = sr_want;
                if (arb_gnt) r_d.st = RS_PRE;
            end
            RS_PRE: begin
                if (banks_idle && dly_zero[0]) begin
                    r_d.st = RS_ISSUE;
                    if (r_q.sr_sel) r_d.cke = 1'b0;
                end
            end
            RS_ISSUE: begin
                dly_load[0] = 1'b1;
                if (r_q.sr_sel) begin
                    r_d.st = RS_SELF;
                end else begin
                    owed_dec = 1'b1;
                    r_d.st   = RS_IDLE;
                end
            end
            RS_SELF: begin
                if (!sr_want) begin
                    r_d.st      = RS_IDLE;
                    r_d.cke     = 1'b1;
                    r_d.sr_sel  = 1'b0;
                    owed_clr    = 1'b1;
                    restart     = 1'b1;
                    dly_load[1] = 1'b1;
                    dly_load[2] = 1'b1;
                end
            end
            default: r_d.st = RS_IDLE;
        endcase

        if (owed_clr) begin
            r_d.owed = '0;
        end else begin
            if (owed_inc) r_d.owed = r_d.owed + OWED_ONE;
            if (owed_dec) r_d.owed = r_d.owed - OWED_ONE;
        end
        r_d.urg = (r_d.owed >= OWED_MAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= RS_IDLE;
            r_q.sr_sel <= 1'b0;
            r_q.cke    <= 1'b1;
            r_q.urg    <= 1'b0;
            r_q.owed   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ref_req     = (r_q.st == RS_ARB);
    assign pre_all_req = (r_q.st == RS_PRE);
    assign cmd_ref     = (r_q.st == RS_ISSUE);
    assign cke         = r_q.cke;
    assign ref_urgent  = r_q.urg;
    assign act_ok      = r_q.cke && (r_q.st != RS_ISSUE) && dly_zero[0] && dly_zero[1];
    assign rd_ok       = act_ok && dly_zero[2];
endmodule

// File: rtl/rs_check.sv
module rs_check #(
    parameter int TRFC_CYC = 10
) (
    input logic clk,
    input logic rst_n,
    input logic banks_idle,
    input logic cmd_ref,
    input logic cke,
    input logic act_ok,
    input logic rd_ok,
    input logic pre_all_req
);
    logic [7:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              since_q <= 8'hFF;
        else if (cmd_ref)        since_q <= 8'd1;
        else if (since_q != 8'hFF) since_q <= since_q + 8'd1;
    end

    AST_REF_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ref |-> $past(banks_idle) && $past(pre_all_req)); // R3

    AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ref |-> (since_q >= 8'(TRFC_CYC))); // R5

    AST_ACT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ref || since_q < 8'(TRFC_CYC)) |-> !act_ok); // R5

    AST_CKE_FALL_WITH_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> cmd_ref); // R6

    AST_NO_REF_IN_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> !cmd_ref); // R6

    AST_EXIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (!act_ok && !rd_ok)); // R7
endmodule

bind ref_sched rs_check #(.TRFC_CYC(TRFC_CYC)) i_rs_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .banks_idle  (banks_idle),
    .cmd_ref     (cmd_ref),
    .cke         (cke),
    .act_ok      (act_ok),
    .rd_ok       (rd_ok),
    .pre_all_req (pre_all_req)
);

// File: tb/test_ref_sched.sv
`timescale 1ns/1ps
module test_ref_sched;
    localparam int CLK_PS = 5000;
    localparam int REFI_NS = 200;
    localparam int REFI = REFI_NS * 1000 / CLK_PS;
    localparam int TRFC = 10;
    localparam int TXSNR = 10;
    localparam int TXSRD = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arb_gnt = 1'b0;
    logic banks_idle = 1'b1;
    logic sr_want = 1'b0;
    logic ref_req, pre_all_req, cmd_ref, cke, ref_urgent, act_ok, rd_ok;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int n_ref = 0;
    int last_ref = -1000;
    bit done = 1'b0;
    int exp_q [$];

    always #2.5 clk = ~clk;

    ref_sched #(
        .CLK_PS(CLK_PS), .REFI_NS(REFI_NS), .TRFC_CYC(TRFC),
        .TXSNR_CYC(TXSNR), .TXSRD_CYC(TXSRD), .POST_MAX(8)
    ) i_ref_sched (
        .clk(clk), .rst_n(rst_n), .arb_gnt(arb_gnt), .banks_idle(banks_idle),
        .sr_want(sr_want), .ref_req(ref_req), .pre_all_req(pre_all_req),
        .cmd_ref(cmd_ref), .cke(cke), .ref_urgent(ref_urgent),
        .act_ok(act_ok), .rd_ok(rd_ok)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // monitor: pops the expected refresh kind (1 = self-refresh entry)
    always @(negedge clk) begin
        if (rst_n && cmd_ref) begin
            int exp_kind;
            exp_kind = (exp_q.size() > 0) ? exp_q.pop_front() : 0;
            check((!cke) == exp_kind[0], "R6 refresh kind (cke low)", int'(!cke), exp_kind);
            check(cyc - last_ref >= TRFC, "R5 refresh spacing", cyc - last_ref, TRFC);
            last_ref = cyc;
            n_ref++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int base;
        int k;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!ref_req && !pre_all_req && !cmd_ref && !ref_urgent, "R1 reset outputs low",
              {ref_req, pre_all_req, cmd_ref, ref_urgent}, 0);
        check(cke && act_ok && rd_ok, "R1 reset enables high", {cke, act_ok, rd_ok}, 7);
        rst_n = 1'b1;

        // R2 interval and request held without grant
        wait_cyc(30);
        check(!ref_req, "R2 no request before first interval", ref_req, 0);
        wait_cyc(45);
        check(ref_req, "R2 request after first interval", ref_req, 1);
        wait_cyc(300);
        check(ref_req, "R2 request held while not granted", ref_req, 1);
        // R4 urgency at the limit
        check(!ref_urgent, "R4 not urgent at 7 owed", ref_urgent, 0);
        wait_cyc(330);
        check(ref_urgent, "R4 urgent at 8 owed", ref_urgent, 1);

        // R4 saturation: 12 ticks by cycle 500, only 8 kept
        wait_cyc(500);
        base = n_ref;
        arb_gnt = 1'b1;
        wait_cyc(505);
        check(n_ref - base == 1, "R3 first refresh after grant", n_ref - base, 1);
        check(!ref_urgent, "R4 urgent released below limit", ref_urgent, 0);
        wait_cyc(630);
        check(n_ref - base == 11, "R4 owed count saturated", n_ref - base, 11);

        // R5 activate window after a refresh
        while (!cmd_ref) @(negedge clk);
        check(!act_ok, "R5 act_ok low in refresh cycle", act_ok, 0);
        repeat (TRFC - 1) @(negedge clk);
        check(!act_ok, "R5 act_ok low at TRFC-1", act_ok, 0);
        @(negedge clk);
        check(act_ok, "R5 act_ok high at TRFC", act_ok, 1);

        // R3 precharge handshake
        banks_idle = 1'b0;
        while (!pre_all_req) @(negedge clk);
        base = n_ref;
        repeat (20) @(negedge clk);
        check(pre_all_req && n_ref == base, "R3 refresh waits for banks idle",
              n_ref - base, 0);
        banks_idle = 1'b1;
        repeat (2) @(negedge clk);
        check(n_ref - base == 1, "R3 refresh after banks idle", n_ref - base, 1);

        // R9 self-refresh takes the pending auto-refresh slot
        arb_gnt = 1'b0;
        while (!ref_req) @(negedge clk);
        sr_want = 1'b1;
        exp_q.push_back(1);
        repeat (2) @(negedge clk);
        arb_gnt = 1'b1;
        base = n_ref;
        repeat (4) @(negedge clk);
        check(n_ref - base == 1 && !cke, "R9 self-refresh entry issued", n_ref - base, 1);
        check(exp_q.size() == 0, "R9 entry consumed expected item", exp_q.size(), 0);
        arb_gnt = 1'b0;
        base = n_ref;
        repeat (150) @(negedge clk);
        check(!cke, "R6 cke held low in self-refresh", cke, 0);
        check(n_ref == base && !ref_req, "R6 no refresh in self-refresh", n_ref - base, 0);

        // R7 / R8 exit
        sr_want = 1'b0;
        @(negedge clk);
        k = 0;
        check(cke && !act_ok && !rd_ok, "R7 cke up, commands held",
              {cke, act_ok, rd_ok}, 4);
        while (k < TXSRD) begin
            @(negedge clk);
            k++;
            if (k == TXSNR - 1) check(!act_ok, "R7 non-read held before exit delay", act_ok, 0);
            if (k == TXSNR)     check(act_ok, "R7 non-read allowed at exit delay", act_ok, 1);
            if (k == 30)        check(!ref_req, "R8 owed cleared on exit", ref_req, 0);
            if (k == 45)        check(ref_req, "R8 interval restarted on exit", ref_req, 1);
            if (k == TXSRD - 1) check(!rd_ok, "R7 read held before read delay", rd_ok, 0);
        end
        check(rd_ok, "R7 read allowed at read delay", rd_ok, 1);

        arb_gnt = 1'b1;
        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule